// File: doc/BRIEF.md
# Digit Blanking and Dimming Controller

This block sits between the stored display state of a four-digit dot-matrix driver and its dot drivers. In every clock cycle it decides, for each digit, whether that digit's dots may be driven and whether the digit shows its stored character or a cursor block. It takes an active-low external blank pin, a cursor-enable pin, and the master-blank, 3-bit intensity and compatibility fields of a control register, together with a per-digit "keep lit" mask and a per-digit cursor mask.

An internal PWM with a 100-step period turns the intensity code into one of eight nonlinear duty cycles. The external blank pin may itself carry a PWM, and the two are ANDed per digit. A cursor digit is shown at half brightness: its enable is also masked on every other internal PWM period. When the compatibility bit is set, intensity, master blank and the keep-lit mask are ignored, and only the blank pin can blank the display. The block never touches the stored character or register contents. It only gates the drive enables.

Top module: `digit_blank_dim`

## Requirements
- R1: While `rst` is high, `drive_o` and `cursor_sel_o` are all zero.
- R2: With `compat_i`=0, blank pin high, master blank 0 and cursor off, each digit is driven for N of every 100 PWM steps, where `level_i` 0..7 gives N = 100, 60, 40, 27, 17, 10, 7, 3.
- R3: With parameter `LOW_POWER`=1, `level_i`=0 gives N=27. The other seven codes are unchanged.
- R4: With `compat_i`=1, the digits are driven continuously whenever `blank_n_i` is high, and are dark whenever it is low. Intensity, master blank and `keep_lit_i` have no effect.
- R5: With `compat_i`=0, a digit whose `keep_lit_i` bit is 0 is dark while `blank_n_i` is low or `master_blank_i` is 1.
- R6: With `compat_i`=0, a digit whose `keep_lit_i` bit is 1 ignores both blank sources but is still dimmed by the intensity PWM.
- R7: With `cursor_en_i`=1, `cursor_sel_o[i]` equals `cursor_mark_i[i]`, and a marked digit is driven on alternate PWM periods only, giving half its normal on-time.
- R8: With `cursor_en_i`=0, `cursor_sel_o` is all zero and the cursor mask does not change on-time.
- R9: Outputs are registered. A change on `blank_n_i` shows on `drive_o` after exactly one rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_n_i | input | 1 | External blank pin, low blanks (may carry a PWM) |
| cursor_en_i | input | 1 | 1 shows cursors on marked digits |
| compat_i | input | 1 | 1 disables intensity, master blank and keep-lit |
| master_blank_i | input | 1 | Control register master blank |
| level_i | input | 3 | Intensity code, 0 brightest, 7 dimmest |
| keep_lit_i | input | NUM_DIGITS | Per-digit immunity to blanking |
| cursor_mark_i | input | NUM_DIGITS | Per-digit cursor flag |
| drive_o | output | NUM_DIGITS | Per-digit dot drive enable |
| cursor_sel_o | output | NUM_DIGITS | 1 selects the all-dots cursor, 0 the character |

## Verification
The bench measures on-time over two full PWM periods for every intensity code, so a wrong threshold or an off-by-one compare (`<=` instead of `<`) shows up as a count of 2N±2. It runs a low-power build next to the default one to catch a code-0 mapping that ignores the build option. It mixes keep-lit digits with blanked ones under both the pin and the master-blank source, and repeats the test with the compatibility bit set. A design that lets keep-lit escape dimming, or lets the register fields act in compatibility mode, produces a wrong per-digit count. Cursor digits must read exactly half. The blank pin latency is checked edge by edge.

// File: rtl/digit_blank_dim_pkg.sv
package digit_blank_dim_pkg;

  // On-time percentage for a 3-bit intensity code.
  function automatic int unsigned level_pct(input logic [2:0] lvl, input bit low_power);
    int unsigned p;
    case (lvl)
      3'd0: p = low_power ? 27 : 100;
      3'd1: p = 60;
      3'd2: p = 40;
      3'd3: p = 27;
      3'd4: p = 17;
      3'd5: p = 10;
      3'd6: p = 7;
      default: p = 3;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dim_pwm.sv
module dim_pwm #(
  parameter int unsigned STEPS     = 100,
  parameter int unsigned PRESCALE  = 1,
  parameter bit          LOW_POWER = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] level,
  output logic       on_o,
  output logic       odd_period_o
);
  import digit_blank_dim_pkg::*;

  localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int unsigned SW = $clog2(STEPS + 1);

  logic [PW-1:0] pre_cnt;
  logic [SW-1:0] step_cnt;
  logic          tick;
  logic          odd_q;
  logic [SW-1:0] thr;

  assign tick = (pre_cnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt  <= '0;
      step_cnt <= '0;
      odd_q    <= 1'b0;
    end else begin
      pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
      if (tick) begin
        if (step_cnt == SW'(STEPS - 1)) begin
          step_cnt <= '0;
          odd_q    <= ~odd_q;
        end else begin
          step_cnt <= step_cnt + 1'b1;
        end
      end
    end
  end

  // Scale the percentage to the step count of one period.
  always_comb begin
    thr = SW'((level_pct(level, LOW_POWER) * STEPS) / 100);
  end

  assign on_o         = (step_cnt < thr);
  assign odd_period_o = odd_q;

endmodule

// File: rtl/digit_gate.sv
module digit_gate #(
  parameter int unsigned NUM_DIGITS = 4
) (
  input  logic                  blank_n,
  input  logic                  compat,
  input  logic                  master_blank,
  input  logic                  pwm_on,
  input  logic                  odd_period,
  input  logic                  cursor_en,
  input  logic [NUM_DIGITS-1:0] keep_lit,
  input  logic [NUM_DIGITS-1:0] cursor_mark,
  output logic [NUM_DIGITS-1:0] drive,
  output logic [NUM_DIGITS-1:0] cursor_sel
);
  logic dim_ok;
  logic shared_vis;

  // In compatibility mode only the pin matters and dimming is off.
  assign dim_ok     = compat | pwm_on;
  assign shared_vis = blank_n & (compat | ~master_blank);

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic vis;
    logic csel;
    assign vis           = shared_vis | (~compat & keep_lit[i]);
    assign csel          = cursor_en & cursor_mark[i];
    assign cursor_sel[i] = csel;
    assign drive[i]      = vis & dim_ok & ~(csel & odd_period);
  end

endmodule

// File: rtl/digit_blank_dim.sv
module digit_blank_dim #(
  parameter int unsigned NUM_DIGITS  = 4,
  parameter int unsigned STEPS       = 100,
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned MIN_RATE_HZ = 10_000,
  parameter bit          LOW_POWER   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  blank_n_i,
  input  logic                  cursor_en_i,
  input  logic                  compat_i,
  input  logic                  master_blank_i,
  input  logic [2:0]            level_i,
  input  logic [NUM_DIGITS-1:0] keep_lit_i,
  input  logic [NUM_DIGITS-1:0] cursor_mark_i,
  output logic [NUM_DIGITS-1:0] drive_o,
  output logic [NUM_DIGITS-1:0] cursor_sel_o
);
  // Largest divider that still repeats the PWM at MIN_RATE_HZ or faster.
  localparam int unsigned RAW_DIV  = CLK_HZ / (MIN_RATE_HZ * STEPS);
  localparam int unsigned PRESCALE = (RAW_DIV < 1) ? 1 : RAW_DIV;

  logic                  pwm_on;
  logic                  odd_period;
  logic [NUM_DIGITS-1:0] drive_d;
  logic [NUM_DIGITS-1:0] csel_d;

  dim_pwm #(
    .STEPS    (STEPS),
    .PRESCALE (PRESCALE),
    .LOW_POWER(LOW_POWER)
  ) u_pwm (
    .clk         (clk),
    .rst         (rst),
    .level       (level_i),
    .on_o        (pwm_on),
    .odd_period_o(odd_period)
  );

  digit_gate #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_gate (
    .blank_n     (blank_n_i),
    .compat      (compat_i),
    .master_blank(master_blank_i),
    .pwm_on      (pwm_on),
    .odd_period  (odd_period),
    .cursor_en   (cursor_en_i),
    .keep_lit    (keep_lit_i),
    .cursor_mark (cursor_mark_i),
    .drive       (drive_d),
    .cursor_sel  (csel_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_o      <= '0;
      cursor_sel_o <= '0;
    end else begin
      drive_o      <= drive_d;
      cursor_sel_o <= csel_d;
    end
  end

endmodule

// File: rtl/digit_blank_dim_chk.sv
module digit_blank_dim_chk #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter bit          LOW_POWER  = 1'b0
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  blank_n_i,
  input logic                  cursor_en_i,
  input logic                  compat_i,
  input logic                  master_blank_i,
  input logic [2:0]            level_i,
  input logic [NUM_DIGITS-1:0] keep_lit_i,
  input logic [NUM_DIGITS-1:0] cursor_mark_i,
  input logic [NUM_DIGITS-1:0] drive_o,
  input logic [NUM_DIGITS-1:0] cursor_sel_o
);

  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (drive_o == '0 && cursor_sel_o == '0));

  a_r2_full_level: assert property (@(posedge clk) disable iff (rst)
    (!compat_i && level_i == 3'd0 && blank_n_i && !master_blank_i && !cursor_en_i && !LOW_POWER)
      |=> (drive_o == '1));

  a_r4_pin_only: assert property (@(posedge clk) disable iff (rst)
    (compat_i && !blank_n_i) |=> (drive_o == '0));

  a_r5_pin_blank: assert property (@(posedge clk) disable iff (rst)
    (!compat_i && !blank_n_i) |=> ((drive_o & ~$past(keep_lit_i)) == '0));

  a_r5_master_blank: assert property (@(posedge clk) disable iff (rst)
    (!compat_i && master_blank_i) |=> ((drive_o & ~$past(keep_lit_i)) == '0));

  a_r7_cursor_select: assert property (@(posedge clk) disable iff (rst)
    cursor_en_i |=> (cursor_sel_o == $past(cursor_mark_i)));

  a_r8_no_cursor: assert property (@(posedge clk) disable iff (rst)
    !cursor_en_i |=> (cursor_sel_o == '0));

endmodule

bind digit_blank_dim digit_blank_dim_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .LOW_POWER (LOW_POWER)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .blank_n_i     (blank_n_i),
  .cursor_en_i   (cursor_en_i),
  .compat_i      (compat_i),
  .master_blank_i(master_blank_i),
  .level_i       (level_i),
  .keep_lit_i    (keep_lit_i),
  .cursor_mark_i (cursor_mark_i),
  .drive_o       (drive_o),
  .cursor_sel_o  (cursor_sel_o)
);

// File: tb/digit_blank_dim_bench.sv
module digit_blank_dim_bench;
  localparam int ND  = 4;
  localparam int WIN = 200; // two PWM periods with prescale 1

  logic          clk = 1'b0;
  logic          rst;
  logic          blank_n, cursor_en, compat, mb;
  logic [2:0]    level;
  logic [ND-1:0] keep, mark;
  logic [ND-1:0] drive, csel, drive_lp, csel_lp;

  int checks = 0;
  int errors = 0;
  int cnt [ND];
  int cnt_lp;

  always #5 clk = ~clk;

  digit_blank_dim #(.NUM_DIGITS(ND), .CLK_HZ(1_000_000)) u_digit_blank_dim (
    .clk(clk), .rst(rst), .blank_n_i(blank_n), .cursor_en_i(cursor_en),
    .compat_i(compat), .master_blank_i(mb), .level_i(level),
    .keep_lit_i(keep), .cursor_mark_i(mark), .drive_o(drive), .cursor_sel_o(csel));

  digit_blank_dim #(.NUM_DIGITS(ND), .CLK_HZ(1_000_000), .LOW_POWER(1'b1)) u_digit_blank_dim_lp (
    .clk(clk), .rst(rst), .blank_n_i(blank_n), .cursor_en_i(cursor_en),
    .compat_i(compat), .master_blank_i(mb), .level_i(level),
    .keep_lit_i(keep), .cursor_mark_i(mark), .drive_o(drive_lp), .cursor_sel_o(csel_lp));

  function automatic int pct(input int code, input bit lp);
    case (code)
      0: return lp ? 27 : 100;
      1: return 60;
      2: return 40;
      3: return 27;
      4: return 17;
      5: return 10;
      6: return 7;
      default: return 3;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic measure();
    for (int d = 0; d < ND; d++) cnt[d] = 0;
    cnt_lp = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      for (int d = 0; d < ND; d++) cnt[d] += int'(drive[d]);
      cnt_lp += int'(drive_lp[0]);
    end
  endtask

  task automatic set_idle();
    blank_n = 1'b1; cursor_en = 1'b0; compat = 1'b0; mb = 1'b0;
    level = 3'd0; keep = '0; mark = '0;
  endtask

  task automatic t_reset();
    set_idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 drive in reset", int'(drive), 0);
    check("R1 cursor_sel in reset", int'(csel), 0);
    rst = 1'b0;
  endtask

  task automatic t_levels();
    set_idle();
    for (int c = 0; c < 8; c++) begin
      level = 3'(c);
      settle();
      measure();
      check($sformatf("R2 level %0d", c), cnt[0], 2 * pct(c, 1'b0));
      check($sformatf("R3 low-power level %0d", c), cnt_lp, 2 * pct(c, 1'b1));
    end
  endtask

  task automatic t_compat();
    set_idle();
    compat = 1'b1; level = 3'd7; mb = 1'b1; keep = 4'b0000;
    settle(); measure();
    for (int d = 0; d < ND; d++) check("R4 compat lit", cnt[d], WIN);
    blank_n = 1'b0; keep = 4'b1111;
    settle(); measure();
    for (int d = 0; d < ND; d++) check("R4 compat pin blank", cnt[d], 0);
  endtask

  task automatic t_blank();
    set_idle();
    keep = 4'b0101; blank_n = 1'b0;
    settle(); measure();
    check("R6 pin keep d0", cnt[0], WIN);
    check("R5 pin blank d1", cnt[1], 0);
    check("R6 pin keep d2", cnt[2], WIN);
    check("R5 pin blank d3", cnt[3], 0);
    blank_n = 1'b1; mb = 1'b1; level = 3'd2;
    settle(); measure();
    check("R6 master keep dimmed d0", cnt[0], 2 * pct(2, 1'b0));
    check("R5 master blank d1", cnt[1], 0);
    check("R5 master blank d3", cnt[3], 0);
  endtask

  task automatic t_cursor();
    set_idle();
    cursor_en = 1'b1; mark = 4'b0011; level = 3'd1;
    settle();
    check("R7 cursor select", int'(csel), 3);
    measure();
    check("R7 cursor half d0", cnt[0], pct(1, 1'b0));
    check("R7 cursor half d1", cnt[1], pct(1, 1'b0));
    check("R7 unmarked full d2", cnt[2], 2 * pct(1, 1'b0));
    cursor_en = 1'b0; mark = 4'b1111;
    settle();
    check("R8 cursor select off", int'(csel), 0);
    measure();
    check("R8 no halving d0", cnt[0], 2 * pct(1, 1'b0));
  endtask

  task automatic t_latency();
    set_idle();
    settle();
    @(negedge clk);
    blank_n = 1'b0;
    #1 check("R9 before edge", int'(drive), 15);
    @(negedge clk);
    check("R9 after one edge", int'(drive), 0);
    blank_n = 1'b1;
    @(negedge clk);
    check("R9 release after one edge", int'(drive), 15);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_idle();
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    t_levels();
    t_compat();
    t_blank();
    t_cursor();
    t_latency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule